// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns the demodulated envelope of an infrared remote-control signal into 32-bit data words. The input is active low: low means carrier present. It is already free of carrier, so no 38 kHz ripple reaches it. The input goes through a synchronizer, and every low and high stretch is timed in microseconds. A free-running prescaler supplies those microseconds, dividing the system clock by `CLK_PER_US`.

A frame opens with a long low leader burst and then a long high space. Thirty-two data bits follow. Each bit starts with a short low burst. Its value comes from the time between its falling edge and the next falling edge. A final trailing burst closes the last bit. Every duration must fall within ±20% of its nominal value. A frame that breaks a timing rule is dropped. A frame that completes is presented on `frame_o` together with a one-cycle strobe.

The decoder is meant to sit behind a receiver module and feed a command dispatcher. The nominal durations are parameters, so the block can run at any clock rate and be tested with a shortened time base.

Top module: `nec_ir_decoder`

## Requirements
- R1: After reset, `frame_valid_o` and `frame_err_o` are 0 and `frame_o` is all zeros. The input passes through a synchronizer, and durations are counted in microsecond ticks of `CLK_PER_US` clock cycles each.
- R2: A low leader burst is accepted only if it lasts between 80% and 120% of `LEADER_US`. A leader that is too short, or one that stays low past 120%, returns the block to idle with no error pulse and no valid strobe.
- R3: After an accepted leader burst, the high space must last between 80% and 120% of `LSPACE_US`. A space that is too short, or one that is still high past 120%, drops the frame and raises `frame_err_o` for one cycle.
- R4: Every data-bit burst must last between 80% and 120% of `BURST_US`. If not, the frame is dropped with a one-cycle error pulse.
- R5: A bit's value comes from the time between its falling edge and the next falling edge. A period within ±20% of `ZERO_US` gives 0, and a period within ±20% of `ONE_US` gives 1. Any other period drops the frame with an error pulse.
- R6: Bits are assembled LSB first: the first data bit received lands in `frame_o[0]` and the last in `frame_o[31]`.
- R7: A frame completes on the falling edge of the trailing burst that closes bit 32. `frame_valid_o` is then high for exactly one cycle, and `frame_o` updates only in that cycle and holds its value until the next complete frame.
- R8: During the data phase, if the line shows no edge for more than `TIMEOUT_US`, the frame is dropped and `frame_err_o` pulses for one cycle.
- R9: `frame_valid_o` and `frame_err_o` are never high together. After any dropped frame, the next well-formed frame is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_n_i | input | 1 | Demodulated infrared envelope, low while carrier is present |
| frame_o | output | 32 | Last completed data word, first received bit at bit 0 |
| frame_valid_o | output | 1 | One-cycle strobe when `frame_o` takes a new word |
| frame_err_o | output | 1 | One-cycle pulse when a frame is dropped after its leader burst was accepted |

## Verification
The cases hardest to reach from the ports are the ones deep inside a frame: a single bit whose period falls in the gap between the zero and one windows, a burst that runs long, or a line that goes quiet in the middle of the data phase. The frame generator in the bench builds a frame edge by edge. It can override the burst and period of one chosen bit, cut the frame short after any number of bits, or hold the line low instead of sending the trailer. Frames with every duration scaled to ±15% confirm that the tolerance windows accept them. After each dropped frame, the bench sends a clean frame to confirm that the block recovers.

// File: rtl/nec_rx_pkg.sv
package nec_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LDR_LOW   = 3'd1,
    ST_LDR_SPACE = 3'd2,
    ST_BIT_BURST = 3'd3,
    ST_BIT_SPACE = 3'd4,
    ST_DONE      = 3'd5
  } rx_state_e;

  // lower edge of a +/-20% window, rounded up
  function automatic int unsigned win_lo(input int unsigned nom);
    return (nom * 4 + 4) / 5;
  endfunction

  // upper edge of a +/-20% window, rounded down
  function automatic int unsigned win_hi(input int unsigned nom);
    return (nom * 6) / 5;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nec_rx_edge.sv
module nec_rx_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_n_i,
  output logic fall_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle line is high, so every stage resets to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b1;
    else        sync_q[0] <= ir_n_i;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o =  prev_q & ~sync_q[SYNC_STAGES-1];
  assign rise_o = ~prev_q &  sync_q[SYNC_STAGES-1];

  // R1: a settled line cannot fall on two consecutive cycles
  assert_fall_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/nec_rx_tick.sv
module nec_rx_tick #(
  parameter int unsigned CLK_PER_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (CLK_PER_US <= 1) begin : g_passthru
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
      end
      assign tick_o = run_q;
    end else begin : g_div
      localparam int unsigned DIV_W = $clog2(CLK_PER_US);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
      logic [DIV_W-1:0] div_q, div_d;
      logic             wrap;

      assign wrap = (div_q == DIV_LAST);

      always_comb begin
        div_d = wrap ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick_o = wrap;

      // R1: one tick per CLK_PER_US cycles, never two in a row
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/nec_rx_timer.sv
module nec_rx_timer #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned CNT_SAT = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] seg_o,
  output logic [CNT_W-1:0] per_o
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_SAT);

  logic [CNT_W-1:0] seg_q, seg_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             seg_clr;

  assign seg_clr = fall_i | rise_i;

  // seg: time since last edge of either kind; per: time since last falling edge
  always_comb begin
    seg_d = seg_q;
    per_d = per_q;
    if (seg_clr)                    seg_d = '0;
    else if (tick_i && seg_q != SAT) seg_d = seg_q + 1'b1;
    if (fall_i)                     per_d = '0;
    else if (tick_i && per_q != SAT) per_d = per_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      per_q <= '0;
    end else begin
      seg_q <= seg_d;
      per_q <= per_d;
    end
  end

  assign seg_o = seg_q;
  assign per_o = per_q;

  // R8: the interval counter never wraps back to a small value without an edge
  assert_seg_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_i) && !$past(rise_i)) |-> (seg_q >= $past(seg_q)));

endmodule

// File: rtl/nec_rx_shift.sv
module nec_rx_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_next_o,
  output logic              last_o
);

  localparam int unsigned    CNT_W    = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // LSB first: new bits enter at the top and move down
  assign word_next_o = {bit_i, word_q[WORD_W-1:1]};
  assign last_o      = (cnt_q == CNT_LAST);

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (shift_i) begin
      word_d = word_next_o;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: bit count only steps by one or restarts at zero
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

endmodule

// File: rtl/nec_ir_decoder.sv
module nec_ir_decoder
  import nec_rx_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 10,
  parameter int unsigned LEADER_US   = 9000,
  parameter int unsigned LSPACE_US   = 4500,
  parameter int unsigned BURST_US    = 560,
  parameter int unsigned ZERO_US     = 1125,
  parameter int unsigned ONE_US      = 2250,
  parameter int unsigned TIMEOUT_US  = 3000,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_n_i,
  output logic [WORD_W-1:0] frame_o,
  output logic              frame_valid_o,
  output logic              frame_err_o
);

  localparam int unsigned CNT_SAT = max2(max2(win_hi(LEADER_US), win_hi(LSPACE_US)),
                                         max2(win_hi(ONE_US), TIMEOUT_US)) + 2;
  localparam int unsigned CNT_W   = $clog2(CNT_SAT + 1);

  localparam logic [CNT_W-1:0] LDR_LO = CNT_W'(win_lo(LEADER_US));
  localparam logic [CNT_W-1:0] LDR_HI = CNT_W'(win_hi(LEADER_US));
  localparam logic [CNT_W-1:0] LSP_LO = CNT_W'(win_lo(LSPACE_US));
  localparam logic [CNT_W-1:0] LSP_HI = CNT_W'(win_hi(LSPACE_US));
  localparam logic [CNT_W-1:0] BRS_LO = CNT_W'(win_lo(BURST_US));
  localparam logic [CNT_W-1:0] BRS_HI = CNT_W'(win_hi(BURST_US));
  localparam logic [CNT_W-1:0] ZER_LO = CNT_W'(win_lo(ZERO_US));
  localparam logic [CNT_W-1:0] ZER_HI = CNT_W'(win_hi(ZERO_US));
  localparam logic [CNT_W-1:0] ONE_LO = CNT_W'(win_lo(ONE_US));
  localparam logic [CNT_W-1:0] ONE_HI = CNT_W'(win_hi(ONE_US));
  localparam logic [CNT_W-1:0] TMO    = CNT_W'(TIMEOUT_US);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic             fall, rise, tick;
  logic [CNT_W-1:0] seg, per;
  logic             sh_clr, sh_shift, sh_bit, sh_last;
  logic [WORD_W-1:0] word_next;

  nec_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ir_n_i (ir_n_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  nec_rx_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick_o (tick)
  );

  nec_rx_timer #(.CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick_i (tick),
    .fall_i (fall),
    .rise_i (rise),
    .seg_o  (seg),
    .per_o  (per)
  );

  nec_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .clr_i       (sh_clr),
    .shift_i     (sh_shift),
    .bit_i       (sh_bit),
    .word_next_o (word_next),
    .last_o      (sh_last)
  );

  rx_state_e         state_q, state_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              abort;

  logic seg_ldr_ok, seg_lsp_ok, seg_brs_ok, per_zero, per_one;
  assign seg_ldr_ok = (seg >= LDR_LO) && (seg <= LDR_HI);
  assign seg_lsp_ok = (seg >= LSP_LO) && (seg <= LSP_HI);
  assign seg_brs_ok = (seg >= BRS_LO) && (seg <= BRS_HI);
  assign per_zero   = (per >= ZER_LO) && (per <= ZER_HI);
  assign per_one    = (per >= ONE_LO) && (per <= ONE_HI);

  always_comb begin
    state_d  = state_q;
    abort    = 1'b0;
    sh_clr   = 1'b0;
    sh_shift = 1'b0;
    sh_bit   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) state_d = ST_LDR_LOW;
      end
      ST_LDR_LOW: begin
        if (rise)                state_d = seg_ldr_ok ? ST_LDR_SPACE : ST_IDLE;
        else if (seg > LDR_HI)   state_d = ST_IDLE;
      end
      ST_LDR_SPACE: begin
        if (fall) begin
          if (seg_lsp_ok) begin
            state_d = ST_BIT_BURST;
            sh_clr  = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end else if (seg > LSP_HI) begin
          abort = 1'b1;
        end
      end
      ST_BIT_BURST: begin
        if (rise) begin
          if (seg_brs_ok) state_d = ST_BIT_SPACE;
          else            abort   = 1'b1;
        end else if (seg > TMO) begin
          abort = 1'b1;
        end
      end
      ST_BIT_SPACE: begin
        if (fall) begin
          if (per_zero || per_one) begin
            sh_shift = 1'b1;
            sh_bit   = per_one;
            state_d  = sh_last ? ST_DONE : ST_BIT_BURST;
          end else begin
            abort = 1'b1;
          end
        end else if (seg > TMO) begin
          abort = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_comb begin
    err_d  = abort;
    data_d = data_q;
    if (sh_shift && sh_last) data_d = word_next;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      data_q  <= data_d;
    end
  end

  assign frame_o       = data_q;
  assign frame_valid_o = (state_q == ST_DONE);
  assign frame_err_o   = err_q;

  // R9: completion and error never coincide
  assert_valid_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(frame_valid_o && frame_err_o));

  // R7: strobe lasts one cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_valid_o |=> !frame_valid_o);

  // R7: completion only follows a bit space that was closed by a falling edge
  assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_valid_o |-> ($past(state_q) == ST_BIT_SPACE));

  // R7: output word moves only together with the strobe
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(frame_o) |-> frame_valid_o);

  // R3 R4 R5 R8: errors only come from states after an accepted leader burst
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_err_o |-> ($past(state_q) inside {ST_LDR_SPACE, ST_BIT_BURST, ST_BIT_SPACE}));

  // R8: no data-phase state outlives the silence limit
  assert_timeout_bound_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q inside {ST_BIT_BURST, ST_BIT_SPACE}) |-> (seg <= TMO + 1'b1));

  // R2: leader burst timing is only entered from idle
  assert_leader_entry_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((state_q == ST_LDR_LOW) && ($past(state_q) != ST_LDR_LOW)) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: tb/nec_ir_decoder_bench.sv
module nec_ir_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 2;
  localparam int LDR  = 200;
  localparam int LSP  = 100;
  localparam int BRS  = 20;
  localparam int ZT   = 40;
  localparam int OT   = 80;
  localparam int TMO  = 110;
  localparam int NONE = 99;

  logic        clk;
  logic        rst_n;
  logic        ir_n;
  logic [31:0] frame;
  logic        valid;
  logic        err;

  int n_vec;
  int n_bad;
  int valid_cnt;
  int err_cnt;
  int run_len;
  int run_max;
  logic [31:0] last_good;

  nec_ir_decoder #(
    .CLK_PER_US (CPU),
    .LEADER_US  (LDR),
    .LSPACE_US  (LSP),
    .BURST_US   (BRS),
    .ZERO_US    (ZT),
    .ONE_US     (OT),
    .TIMEOUT_US (TMO),
    .WORD_W     (32),
    .SYNC_STAGES(2)
  ) u_nec_ir_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .ir_n_i       (ir_n),
    .frame_o      (frame),
    .frame_valid_o(valid),
    .frame_err_o  (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        valid_cnt++;
        run_len++;
        if (run_len > run_max) run_max = run_len;
      end else begin
        run_len = 0;
      end
      if (err) err_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int us);
    ir_n = lvl;
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] word, input int ldr, input int lsp, input int brs,
                      input int zt, input int ot, input int nbits, input int bad_idx,
                      input int bad_brs, input int bad_tot, input bit trailer, input int stuck);
    drive(1'b0, ldr);
    drive(1'b1, lsp);
    for (int i = 0; i < nbits; i++) begin
      int b;
      int t;
      b = (i == bad_idx) ? bad_brs : brs;
      t = (i == bad_idx) ? bad_tot : (word[i] ? ot : zt);
      drive(1'b0, b);
      drive(1'b1, t - b);
    end
    if (stuck > 0)    drive(1'b0, stuck);
    else if (trailer) drive(1'b0, brs);
    drive(1'b1, TMO + 40);
  endtask

  task automatic run_case(input string req, input logic [31:0] word, input int ldr, input int lsp,
                          input int brs, input int zt, input int ot, input int nbits,
                          input int bad_idx, input int bad_brs, input int bad_tot,
                          input bit trailer, input int stuck, input int exp_v, input int exp_e);
    int v0;
    int e0;
    v0 = valid_cnt;
    e0 = err_cnt;
    send(word, ldr, lsp, brs, zt, ot, nbits, bad_idx, bad_brs, bad_tot, trailer, stuck);
    check({req, " valid count"}, 32'(valid_cnt - v0), 32'(exp_v));
    check({req, " error count"}, 32'(err_cnt - e0), 32'(exp_e));
    if (exp_v == 1) last_good = word;
    check({req, " frame word"}, frame, last_good);
  endtask

  task automatic good(input string req, input logic [31:0] word);
    run_case(req, word, LDR, LSP, BRS, ZT, OT, 32, NONE, 0, 0, 1'b1, 0, 1, 0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; valid_cnt = 0; err_cnt = 0;
    run_len = 0; run_max = 0; last_good = '0;
    ir_n = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check("R1 reset valid", 32'(valid), 32'd0);
    check("R1 reset err", 32'(err), 32'd0);
    check("R1 reset word", frame, 32'd0);

    // R6 R7: clean frames with varied data
    good("R6 all zeros", 32'h0000_0000);
    good("R6 all ones", 32'hFFFF_FFFF);
    good("R6 first bit only", 32'h0000_0001);
    good("R6 last bit only", 32'h8000_0000);
    good("R6 mixed", 32'h3CA5_C35A);
    good("R7 second mixed", 32'h1234_5678);
    check("R7 strobe width", 32'(run_max), 32'd1);

    // R2 R3 R4 R5: all durations 15% long, then 15% short, still accepted
    run_case("R5 long skew", 32'hF0F0_0F0F, 230, 115, 23, 46, 92, 32, NONE, 0, 0, 1'b1, 0, 1, 0);
    run_case("R5 short skew", 32'h0F0F_F0F0, 170, 85, 17, 34, 68, 32, NONE, 0, 0, 1'b1, 0, 1, 0);

    // R2: leader too short, silent drop; then recovery
    run_case("R2 short leader", 32'hAAAA_5555, 120, LSP, BRS, ZT, OT, 32, NONE, 0, 0, 1'b1, 0, 0, 0);
    good("R9 recover after short leader", 32'h0BAD_F00D);
    // R2: leader held too long, silent drop
    run_case("R2 long leader", 32'h5555_AAAA, 400, LSP, BRS, ZT, OT, 32, NONE, 0, 0, 1'b1, 0, 0, 0);

    // R3: leader space too short and too long
    run_case("R3 short space", 32'h1111_2222, LDR, 60, BRS, ZT, OT, 32, NONE, 0, 0, 1'b1, 0, 0, 1);
    run_case("R3 long space", 32'h3333_4444, LDR, 150, BRS, ZT, OT, 32, NONE, 0, 0, 1'b1, 0, 0, 1);
    good("R9 recover after space error", 32'hC001_D00D);

    // R4: one bit burst too long, at several positions
    for (int p = 0; p < 32; p += 13) begin
      run_case("R4 long burst", 32'h9999_6666, LDR, LSP, BRS, ZT, OT, 32, p, 30, 60, 1'b1, 0, 0, 1);
    end
    // R4: one bit burst too short
    run_case("R4 short burst", 32'h9999_6666, LDR, LSP, BRS, ZT, OT, 32, 7, 10, 40, 1'b1, 0, 0, 1);

    // R5: bit period in the gap between windows, first and last bit
    run_case("R5 gap period first", 32'h7777_8888, LDR, LSP, BRS, ZT, OT, 32, 0, BRS, 56, 1'b1, 0, 0, 1);
    run_case("R5 gap period last", 32'h7777_8888, LDR, LSP, BRS, ZT, OT, 32, 31, BRS, 56, 1'b1, 0, 0, 1);
    good("R9 recover after bit error", 32'h600D_CAFE);

    // R8: silence during a bit space, missing trailer, and a stuck-low burst
    run_case("R8 quiet space", 32'hFFFF_FFFF, LDR, LSP, BRS, ZT, OT, 10, NONE, 0, 0, 1'b0, 0, 0, 1);
    run_case("R8 missing trailer", 32'h2468_ACE0, LDR, LSP, BRS, ZT, OT, 32, NONE, 0, 0, 1'b0, 0, 0, 1);
    run_case("R8 stuck low", 32'h0000_0000, LDR, LSP, BRS, ZT, OT, 5, NONE, 0, 0, 1'b0, 150, 0, 1);
    good("R9 recover after timeout", 32'hDEAD_BEEF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule